// File: doc/BRIEF.md
# Nested Loop Iteration Counter

This block tracks the iteration position of a loop nest with up to six levels. Each level holds its own iteration counter and its own configured extent. A configured level count decides how many levels take part. On every step the block advances the nest by one iteration, in the same order as nested for-loops with level 0 innermost. It also reports, as a 3-bit select, which level is the one that advances.

The select does not carry a flat iteration count. It names the level whose counter moves. Address and schedule generators use it to choose the per-level increment that they add to a running value. When every participating level sits on its last iteration, the next step returns the whole nest to zero. The block then raises a one-cycle completion flag.

The control has two states. In `ST_COUNT` the nest iterates normally. `ST_DONE` lasts for the single cycle after a wrapping step, and it is the only state in which `done` is high. The transitions are:
- `ST_COUNT -> ST_DONE` on a wrapping step.
- `ST_DONE -> ST_DONE` on another wrapping step.
- `ST_DONE -> ST_COUNT` on any other cycle.
- Reset or restart moves either state to `ST_COUNT`.

Top module: `loop_nest_counter`

## Requirements
- R1: Synchronous reset `rst` or the input `restart` clears every level counter to zero and leaves `done` low in the following cycle.
- R2: When `step` is low and no clear is requested, every level counter keeps its value.
- R3: Level i runs from 0 to range_i-1. A range of 0 or 1 means a single iteration at value 0. Level i occupies bits [10*i+9:10*i] of both `loop_ranges` and `loop_counts`.
- R4: `adv_sel` combinationally gives the lowest active level whose counter is below its last iteration. On a step, that level increments by one, every lower level returns to zero, and every higher level keeps its value.
- R5: When every active level is at its last iteration, `adv_sel` reads 0. A step then returns all counters to zero.
- R6: Levels whose index is at or above the effective level count stay at zero and never appear on `adv_sel`.
- R7: A `loop_dims` value of 0 acts as 1, and any value above 6 acts as 6.
- R8: `done` is high for exactly the one cycle after a wrapping step, and is low at all other times.
- R9: When `restart` and `step` arrive in the same cycle, `restart` wins: counters become zero and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Synchronous clear of the nest, active high |
| step | input | 1 | Advance the nest by one iteration |
| loop_dims | input | 4 | Number of active levels (clamped to 1..6) |
| loop_ranges | input | 60 | Six 10-bit extents, level 0 in the low bits |
| adv_sel | output | 3 | Level that advances on the next step |
| loop_counts | output | 60 | Six 10-bit counters, level 0 in the low bits |
| done | output | 1 | One-cycle pulse after the nest wraps |

## Verification
Two functions can fall in the same cycle: the wrapping step that completes the nest, and a restart. The bench provokes this by walking a nest to its final iteration and then raising `step` and `restart` together. The judgement is that the counters read zero afterwards and `done` stays low, so the clear takes priority over the completion. A second overlap is also covered. A step that arrives while `done` is still high must advance the nest normally, and `done` must then drop.

// File: rtl/nest_pkg.sv
package nest_pkg;
    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_DONE  = 1'b1
    } nest_state_t;
endpackage

// File: rtl/nest_level_ctr.sv
module nest_level_ctr #(
    parameter int RANGE_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               active,
    input  logic               step,
    input  logic               inc,
    input  logic               clr,
    input  logic [RANGE_W-1:0] rng,
    output logic [RANGE_W-1:0] cnt,
    output logic               last
);
    logic [RANGE_W:0] cnt_plus;

    assign cnt_plus = {1'b0, cnt} + {{RANGE_W{1'b0}}, 1'b1};
    // ranges 0 and 1 both mean a single iteration
    assign last = cnt_plus >= {1'b0, rng};

    always_ff @(posedge clk) begin
        if (rst || restart || !active) begin
            cnt <= '0;
        end else if (step && clr) begin
            cnt <= '0;
        end else if (step && inc) begin
            cnt <= cnt_plus[RANGE_W-1:0];
        end
    end

    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !restart && active) |=> $stable(cnt));
    // R4
    a_r4_increment: assert property (@(posedge clk) disable iff (rst)
        (step && inc && !clr && active && !restart) |=> (cnt == $past(cnt) + RANGE_W'(1)));
    // R6
    a_r6_inactive_zero: assert property (@(posedge clk) disable iff (rst)
        (!active) |=> (cnt == '0));
endmodule

// File: rtl/nest_sel_pick.sv
module nest_sel_pick #(
    parameter int LEVELS = 6,
    parameter int SEL_W  = 3
) (
    input  logic [LEVELS-1:0] want,
    output logic [SEL_W-1:0]  sel,
    output logic              any
);
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = LEVELS - 1; i >= 0; i--) begin
            if (want[i]) begin
                sel = SEL_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/loop_nest_counter.sv
module loop_nest_counter #(
    parameter int LEVELS  = 6,
    parameter int RANGE_W = 10,
    parameter int DIM_W   = 4,
    parameter int SEL_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      restart,
    input  logic                      step,
    input  logic [DIM_W-1:0]          loop_dims,
    input  logic [LEVELS*RANGE_W-1:0] loop_ranges,
    output logic [SEL_W-1:0]          adv_sel,
    output logic [LEVELS*RANGE_W-1:0] loop_counts,
    output logic                      done
);
    import nest_pkg::*;

    localparam logic [DIM_W-1:0] MAX_DIM = DIM_W'(LEVELS);

    nest_state_t        state_q, state_d;
    logic [DIM_W-1:0]   dim_eff;
    logic [LEVELS-1:0]  active, last, want;
    logic               any;
    logic               wrap;

    // R7: clamp the level count into 1..LEVELS
    always_comb begin
        if (loop_dims == '0) begin
            dim_eff = DIM_W'(1);
        end else if (loop_dims > MAX_DIM) begin
            dim_eff = MAX_DIM;
        end else begin
            dim_eff = loop_dims;
        end
    end

    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_level
            logic inc_g, clr_g;
            assign active[g] = DIM_W'(g) < dim_eff;
            assign want[g]   = active[g] && !last[g];
            assign inc_g     = any && (adv_sel == SEL_W'(g));
            assign clr_g     = !any || (SEL_W'(g) < adv_sel);

            nest_level_ctr #(.RANGE_W(RANGE_W)) i_ctr (
                .clk     (clk),
                .rst     (rst),
                .restart (restart),
                .active  (active[g]),
                .step    (step),
                .inc     (inc_g),
                .clr     (clr_g),
                .rng     (loop_ranges[g*RANGE_W +: RANGE_W]),
                .cnt     (loop_counts[g*RANGE_W +: RANGE_W]),
                .last    (last[g])
            );
        end
    endgenerate

    nest_sel_pick #(.LEVELS(LEVELS), .SEL_W(SEL_W)) i_pick (
        .want (want),
        .sel  (adv_sel),
        .any  (any)
    );

    assign wrap = step && !any && !restart;

    // state register
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state_q <= ST_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: if (wrap) state_d = ST_DONE;
            ST_DONE:  state_d = wrap ? ST_DONE : ST_COUNT;
            default:  state_d = ST_COUNT;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_DONE: done = 1'b1;
            default: done = 1'b0;
        endcase
    end

    // R1 / R9
    a_r1_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (loop_counts == '0 && !done));
    // R8
    a_r8_done_after_step: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(step && !restart));
    // R5
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (step && !any && !restart) |=> (loop_counts == '0 && done));
    // R3 / R6
    a_r3_sel_in_range: assert property (@(posedge clk) disable iff (rst)
        (DIM_W'(adv_sel) < dim_eff));
endmodule

// File: tb/test_loop_nest_counter.sv
module test_loop_nest_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        restart = 1'b0;
    logic        step = 1'b0;
    logic [3:0]  loop_dims = 4'd1;
    logic [59:0] loop_ranges = '0;
    logic [2:0]  adv_sel;
    logic [59:0] loop_counts;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;
    int e_cnt [6];
    logic e_done = 1'b0;

    always #4 clk = ~clk;

    loop_nest_counter i_loop_nest_counter (
        .clk(clk), .rst(rst), .restart(restart), .step(step),
        .loop_dims(loop_dims), .loop_ranges(loop_ranges),
        .adv_sel(adv_sel), .loop_counts(loop_counts), .done(done)
    );

    function automatic int eff_dim();
        if (loop_dims == 0) return 1;
        if (loop_dims > 6) return 6;
        return int'(loop_dims);
    endfunction

    function automatic int rng_of(int i);
        int r = int'(loop_ranges[i*10 +: 10]);
        return (r < 1) ? 1 : r;
    endfunction

    // lowest active level below its last iteration, or -1
    function automatic int exp_pick();
        for (int i = 0; i < eff_dim(); i++)
            if (e_cnt[i] + 1 < rng_of(i)) return i;
        return -1;
    endfunction

    function automatic logic [59:0] exp_counts();
        logic [59:0] v = '0;
        for (int i = 0; i < 6; i++) v[i*10 +: 10] = 10'(e_cnt[i]);
        return v;
    endfunction

    task automatic check(string tag);
        int p = exp_pick();
        logic [2:0] es = (p < 0) ? 3'd0 : 3'(p);
        n_checks++;
        if (loop_counts !== exp_counts() || adv_sel !== es || done !== e_done) begin
            n_errors++;
            $display("FAIL %s: counts=%h sel=%0d done=%b expected counts=%h sel=%0d done=%b",
                     tag, loop_counts, adv_sel, done, exp_counts(), es, e_done);
        end
    endtask

    // one clock: drive at negedge, update model at posedge, check after
    task automatic cyc(logic s, logic r, string tag);
        int p;
        @(negedge clk);
        step = s;
        restart = r;
        p = exp_pick();
        @(posedge clk);
        if (r) begin
            foreach (e_cnt[i]) e_cnt[i] = 0;
            e_done = 1'b0;
        end else begin
            e_done = s && (p < 0);
            if (s) begin
                if (p < 0) begin
                    foreach (e_cnt[i]) e_cnt[i] = 0;
                end else begin
                    e_cnt[p]++;
                    for (int i = 0; i < p; i++) e_cnt[i] = 0;
                end
            end
        end
        for (int i = eff_dim(); i < 6; i++) e_cnt[i] = 0;
        #2;
        check(tag);
    endtask

    task automatic setup(int d, int r0, int r1, int r2, int r3, int r4, int r5);
        @(negedge clk);
        loop_dims = 4'(d);
        loop_ranges = {10'(r5), 10'(r4), 10'(r3), 10'(r2), 10'(r1), 10'(r0)};
        cyc(1'b0, 1'b1, "R1 restart");
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        foreach (e_cnt[i]) e_cnt[i] = 0;
        e_done = 1'b0;
        check("R1 reset state");
    endtask

    task automatic t_two_level();
        setup(2, 3, 2, 5, 0, 0, 0);
        for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0, "R4 two-level walk");
        cyc(1'b1, 1'b0, "R5 wrap");
        cyc(1'b0, 1'b0, "R8 done drops");
    endtask

    task automatic t_hold();
        setup(3, 2, 3, 2, 0, 0, 0);
        cyc(1'b1, 1'b0, "R4 step");
        cyc(1'b1, 1'b0, "R4 step");
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, "R2 hold without step");
    endtask

    task automatic t_inactive();
        setup(2, 2, 2, 7, 7, 0, 0);
        for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0, "R6 inactive levels");
    endtask

    task automatic t_clamp();
        setup(0, 2, 9, 9, 9, 9, 9);
        cyc(1'b1, 1'b0, "R7 dims zero acts as one");
        cyc(1'b1, 1'b0, "R7 dims zero wraps");
        setup(15, 1, 1, 1, 1, 1, 2);
        cyc(1'b0, 1'b0, "R7 dims above six, sel 5");
        cyc(1'b1, 1'b0, "R7 top level advances");
        cyc(1'b1, 1'b0, "R7 wrap of six levels");
    endtask

    task automatic t_range_zero();
        setup(2, 0, 3, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, "R3 zero range single iteration");
        setup(1, 1, 0, 0, 0, 0, 0);
        cyc(1'b1, 1'b0, "R8 wrap every step");
        cyc(1'b1, 1'b0, "R8 done stays with back-to-back wraps");
        cyc(1'b0, 1'b0, "R8 done falls");
    endtask

    task automatic t_collide();
        setup(2, 2, 2, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, "R4 reach last");
        cyc(1'b1, 1'b1, "R9 restart beats wrap");
        cyc(1'b0, 1'b0, "R9 no done pulse");
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0, "R5 wrap again");
        cyc(1'b1, 1'b0, "R8 step during done");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                t_reset();
                t_two_level();
                t_hold();
                t_inactive();
                t_clamp();
                t_range_zero();
                t_collide();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule